// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit with Overflow and Equality Flags

This block is the combinational execute-stage datapath of a small 32-bit processor. Two operands, `x_i` and `y_i`, and a 4-bit operation code on `op_i` select one of eleven functions:

- three shifts, in which `y_i` is the value shifted and the low bits of `x_i` give the distance;
- signed and unsigned addition;
- signed and unsigned subtraction, always computing `x_i - y_i`;
- bitwise AND and OR;
- signed and unsigned less-than tests.

The result appears on `res_o` in the same cycle. No register lies on any path.

Two flags come with the result. `ovf_o` reports two's-complement overflow, but only for the signed add and signed subtract codes. The decoder uses it to trap or branch on overflow. `eq_o` reports operand equality whatever code is selected, so branch-on-equal logic can use it directly.

One shared adder serves add, subtract and both comparisons. A logarithmic shifter serves all three shifts.

Top module: `alu_core`

## Requirements
- R1: Code 0 shifts `y_i` left by the shift distance and fills the vacated low bits with zeros.
- R2: Code 1 shifts `y_i` right by the shift distance and fills the vacated high bits with zeros.
- R3: Code 2 shifts `y_i` right by the shift distance and fills the vacated high bits with copies of `y_i[31]`.
- R4: Codes 5 and 6 return `x_i + y_i` modulo 2^32. Codes 7 and 8 return `x_i - y_i` modulo 2^32.
- R5: `ovf_o` is 1 only when the code is 5 or 7 and the true signed result does not fit in 32 bits. It is 0 for every other code, including codes 6 and 8.
- R6: `eq_o` is 1 exactly when `x_i == y_i`, under every operation code.
- R7: Code 11 returns 1 when `x_i < y_i` as two's-complement numbers and 0 otherwise. This holds even when `x_i - y_i` overflows.
- R8: Code 12 returns 1 when `x_i < y_i` as unsigned numbers and 0 otherwise.
- R9: Code 9 returns `x_i & y_i`. Code 10 returns `x_i | y_i`.
- R10: Codes 3, 4, 13, 14 and 15 return a zero result with `ovf_o` at 0.
- R11: The shift distance is `x_i[4:0]`. Bits 31 to 5 of `x_i` have no effect on any shift result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 32 | First operand; supplies the shift distance for the shift codes |
| y_i | input | 32 | Second operand; the value shifted by the shift codes |
| op_i | input | 4 | Operation code |
| res_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of the signed add and subtract codes |
| eq_o | output | 1 | High when the operands are equal |

## Verification
The checker evaluates its properties whenever the inputs settle. It therefore assumes that `x_i`, `y_i` and `op_i` are always driven to known two-state values, and that nothing else changes them between evaluations. The bench drives all three inputs together on the rising clock edge and only ever from fully specified constants or computed values. It reads the outputs half a period later, once the combinational paths have settled. Every operation code is applied, including the five unused ones. Operand patterns cover the sign-boundary values at which overflow and the signed comparison diverge.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_SHRA = 4'd2,
    OP_ADD  = 4'd5,
    OP_ADDU = 4'd6,
    OP_SUB  = 4'd7,
    OP_SUBU = 4'd8,
    OP_AND  = 4'd9,
    OP_OR   = 4'd10,
    OP_LTS  = 4'd11,
    OP_LTU  = 4'd12
  } alu_op_e;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  val_o
);
  logic                          fill;
  logic [SHAMT_W:0][DATA_W-1:0]  stage;

  assign fill     = arith_i & val_i[DATA_W-1];
  assign stage[0] = val_i;

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stage[i+1] = !amt_i[i] ? stage[i] :
                        (left_i ? (stage[i] << STEP)
                                : {{STEP{fill}}, stage[i][DATA_W-1:STEP]});
  end

  assign val_o = stage[SHAMT_W];
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] b_eff;

  assign b_eff              = sub_i ? ~b_i : b_i;
  assign {carry_o, sum_o}   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign ovf_o              = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
                              (sum_o[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] diff_i,
  input  logic              carry_i,
  output logic              eq_o,
  output logic              lts_o,
  output logic              ltu_o
);
  assign eq_o  = (a_i == b_i);
  assign lts_o = (a_i[DATA_W-1] != b_i[DATA_W-1]) ? a_i[DATA_W-1] : diff_i[DATA_W-1];
  assign ltu_o = ~carry_i;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 4,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o,
  output logic              eq_o
);
  import alu_pkg::*;

  alu_op_e           op;
  logic [DATA_W-1:0] sh_val, as_sum;
  logic              sh_left, sh_arith, as_sub, as_carry, as_ovf, lts, ltu;

  assign op       = alu_op_e'(op_i);
  assign sh_left  = (op == OP_SHL);
  assign sh_arith = (op == OP_SHRA);
  assign as_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_LTS) || (op == OP_LTU);

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .val_i(y_i), .amt_i(x_i[SHAMT_W-1:0]), .left_i(sh_left),
    .arith_i(sh_arith), .val_o(sh_val)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(x_i), .b_i(y_i), .sub_i(as_sub),
    .sum_o(as_sum), .carry_o(as_carry), .ovf_o(as_ovf)
  );

  alu_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_i(x_i), .b_i(y_i), .diff_i(as_sum), .carry_i(as_carry),
    .eq_o(eq_o), .lts_o(lts), .ltu_o(ltu)
  );

  always_comb begin
    res_o = '0;
    unique case (op)
      OP_SHL, OP_SHR, OP_SHRA:          res_o = sh_val;
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: res_o = as_sum;
      OP_AND:                           res_o = x_i & y_i;
      OP_OR:                            res_o = x_i | y_i;
      OP_LTS:                           res_o = {{(DATA_W-1){1'b0}}, lts};
      OP_LTU:                           res_o = {{(DATA_W-1){1'b0}}, ltu};
      default:                          res_o = '0;
    endcase
  end

  assign ovf_o = ((op == OP_ADD) || (op == OP_SUB)) && as_ovf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4
) (
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] res_o,
  input logic              ovf_o,
  input logic              eq_o
);
  logic unused_code, cmp_code;
  assign unused_code = (op_i == 4'd3) || (op_i == 4'd4) || (op_i >= 4'd13);
  assign cmp_code    = (op_i == 4'd11) || (op_i == 4'd12);

  always_comb begin
    AST_OVF_ONLY_SIGNED: assert (!ovf_o || op_i == 4'd5 || op_i == 4'd7)
      else $error("overflow on code %0d", op_i); // R5
    AST_UNUSED_ZERO: assert (!unused_code || (res_o == '0 && !ovf_o))
      else $error("unused code %0d not zero", op_i); // R10
    AST_CMP_ONE_BIT: assert (!cmp_code || res_o[DATA_W-1:1] == '0)
      else $error("compare result wide"); // R7
    AST_CMP_EQ_FALSE: assert (!(cmp_code && eq_o) || res_o == '0)
      else $error("equal operands compare less"); // R8
    AST_SUB_EQ_ZERO: assert (!(eq_o && (op_i == 4'd7 || op_i == 4'd8)) || (res_o == '0 && !ovf_o))
      else $error("equal operands subtract nonzero"); // R4
    AST_EQ_MATCH: assert (!eq_o || (x_i ^ y_i) == '0)
      else $error("equal flag with differing operands"); // R6
  end
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .x_i(x_i), .y_i(y_i), .op_i(op_i), .res_o(res_o), .ovf_o(ovf_o), .eq_o(eq_o)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] x, y, res;
  logic [3:0]  op;
  logic        ovf, eq;

  alu_core u0 (.x_i(x), .y_i(y), .op_i(op), .res_o(res), .ovf_o(ovf), .eq_o(eq));

  typedef struct {
    logic [31:0] r;
    logic        v;
    logic        e;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic [3:0] c, string tag);
    exp_t   t;
    longint s;
    t.r = 32'd0; t.v = 1'b0; t.e = (a == b); t.tag = tag;
    case (c)
      4'd0:  t.r = b << a[4:0];
      4'd1:  t.r = b >> a[4:0];
      4'd2:  t.r = $signed(b) >>> a[4:0];
      4'd5, 4'd6: begin
        t.r = a + b;
        s = longint'($signed(a)) + longint'($signed(b));
        t.v = (c == 4'd5) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      4'd7, 4'd8: begin
        t.r = a - b;
        s = longint'($signed(a)) - longint'($signed(b));
        t.v = (c == 4'd7) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      4'd9:  t.r = a & b;
      4'd10: t.r = a | b;
      4'd11: t.r = {31'd0, $signed(a) < $signed(b)};
      4'd12: t.r = {31'd0, a < b};
      default: t.r = 32'd0;
    endcase
    return t;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [3:0] c, string tag);
    @(posedge clk);
    x = a; y = b; op = c;
    q.push_back(model(a, b, c, tag));
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t t;
      t = q.pop_front();
      checks++;
      if (res !== t.r || ovf !== t.v || eq !== t.e) begin
        errors++;
        $display("FAIL %s op=%0d res=%h ovf=%b eq=%b expected res=%h ovf=%b eq=%b",
                 t.tag, op, res, ovf, eq, t.r, t.v, t.e);
      end
    end
  end

  initial begin
    x = '0; y = '0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(32'h0, 32'h0, 4'd0, "reset state R6");
    // R1 logical left
    drive(32'd4, 32'h8000_00F1, 4'd0, "R1");
    drive(32'd31, 32'h0000_0003, 4'd0, "R1");
    // R2 logical right
    drive(32'd8, 32'hF000_1234, 4'd1, "R2");
    drive(32'd0, 32'hDEAD_BEEF, 4'd1, "R2");
    // R3 arithmetic right
    drive(32'd4, 32'h8000_0010, 4'd2, "R3");
    drive(32'd31, 32'h8000_0000, 4'd2, "R3");
    drive(32'd5, 32'h7000_0000, 4'd2, "R3");
    // R11 upper shift distance bits ignored
    drive(32'hFFFF_FFE3, 32'h0000_00FF, 4'd0, "R11");
    drive(32'h0000_0120, 32'h8000_0000, 4'd2, "R11");
    drive(32'hABCD_EF01, 32'h1234_5678, 4'd1, "R11");
    // R4 / R5 add and subtract
    drive(32'h7FFF_FFFF, 32'd1, 4'd5, "R5 add ovf");
    drive(32'h7FFF_FFFF, 32'd1, 4'd6, "R5 addu no ovf");
    drive(32'h8000_0000, 32'h8000_0000, 4'd5, "R5 neg add ovf");
    drive(32'hFFFF_FFFF, 32'd1, 4'd5, "R4 add wrap");
    drive(32'h8000_0000, 32'd1, 4'd7, "R5 sub ovf");
    drive(32'h8000_0000, 32'd1, 4'd8, "R5 subu no ovf");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd7, "R5 sub ovf pos");
    drive(32'd5, 32'd9, 4'd8, "R4 sub");
    drive(32'd9, 32'd9, 4'd7, "R4 R6 sub equal");
    // R9 logic
    drive(32'hF0F0_A5A5, 32'h0FF0_FF00, 4'd9, "R9 and");
    drive(32'hF0F0_A5A5, 32'h0FF0_FF00, 4'd10, "R9 or");
    // R7 signed less-than
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'd11, "R7 ovf case");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'd11, "R7 ovf case");
    drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'd11, "R7");
    drive(32'd3, 32'd3, 4'd11, "R7 equal");
    // R8 unsigned less-than
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'd12, "R8");
    drive(32'hFFFF_FFFF, 32'd0, 4'd12, "R8");
    drive(32'd0, 32'd0, 4'd12, "R8 equal");
    // R10 unused codes
    drive(32'h7FFF_FFFF, 32'd1, 4'd3, "R10");
    drive(32'h7FFF_FFFF, 32'd1, 4'd4, "R10");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd13, "R10 R6");
    drive(32'h8000_0000, 32'd1, 4'd14, "R10");
    drive(32'h1234, 32'h5678, 4'd15, "R10");
    // R6 equality under several codes
    drive(32'hCAFE_0001, 32'hCAFE_0001, 4'd10, "R6");
    drive(32'hCAFE_0001, 32'hCAFE_0003, 4'd10, "R6");
    // sweep every code over a few patterns
    for (int c = 0; c < 16; c++) begin
      drive(32'h0000_0011, 32'h9ABC_DEF0, 4'(c), "sweep R1 R2 R3 R4 R9 R10");
      drive(32'hFFFF_FF80, 32'h0000_007F, 4'(c), "sweep R5 R7 R8");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule